// File: doc/BRIEF.md
# Voltage and Frequency Operating-Point Governor

This block selects the performance level of a processor from a stream of utilization measurements and an over-temperature alarm. Level 0 is the fastest voltage and clock pair. Each higher index is a slower, lower-voltage pair. Only indices from 0 to `NUM_STATES-1` exist, and each one stands for a validated pair. After reset the block sits at the slowest level.

Utilization arrives as a percentage together with a one-cycle valid strobe. A sample above the upper threshold counts toward a speed-up. A sample below the lower threshold counts toward a slow-down. The block moves one level only after `win_len` consecutive samples have fallen in the same band. An over-temperature alarm skips this window and starts a one-level slow-down at once.

Each move runs as two request phases, and every phase waits for the acknowledge from the external regulator and clock generator. A speed-up raises the voltage before the clock. A slow-down lowers the clock before the voltage. The CPU stall output stays high for the whole move, so the core never runs at a clock the current voltage cannot support.

Top module: `dvfs_governor`

## Requirements
- R1: After reset, `pstate` and `pstate_tgt` equal `NUM_STATES-1`, and `req_volt`, `req_freq` and `cpu_stall` are all 0.
- R2: When `win_len` consecutive accepted samples have `util_pct > UP_THR` (default 80), a speed-up begins on the edge that takes the last of them: `cpu_stall` rises and `pstate_tgt` becomes `pstate-1`.
- R3: When `win_len` consecutive accepted samples have `util_pct < DN_THR` (default 30), a slow-down begins on the edge that takes the last of them, and `pstate_tgt` becomes `pstate+1`.
- R4: With fewer than `win_len` consecutive same-band samples, no move starts. A sample inside the band from `DN_THR` to `UP_THR` inclusive clears the count. A sample in the opposite band restarts the count at one.
- R5: While idle and not at the slowest level, `over_temp` starts a slow-down on the next edge without any window. In the same cycle it overrides a speed-up that would otherwise fire.
- R6: A speed-up asserts `req_volt` alone in its first phase and `req_freq` alone in its second phase.
- R7: A slow-down asserts `req_freq` alone in its first phase and `req_volt` alone in its second phase.
- R8: Each phase request stays high until `xfer_ack` is sampled. `cpu_stall` is high from the start of a move through the edge that takes the second acknowledge. `pstate` changes by exactly one, and only on that edge.
- R9: A speed-up request at level 0 is ignored, and so is a slow-down or thermal request at level `NUM_STATES-1`. In both cases there is no stall and the level is unchanged.
- R10: Samples that arrive while `cpu_stall` is high are discarded, and the band count starts from zero after the move completes.
- R11: `req_volt` and `req_freq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| util_pct | input | UTIL_W | Utilization sample in percent |
| util_vld | input | 1 | One-cycle strobe marking a new sample |
| win_len | input | WIN_W | Stability window in samples (0 acts as 1) |
| over_temp | input | 1 | Over-temperature alarm |
| xfer_ack | input | 1 | Current phase has settled |
| pstate | output | IDX_W | Level currently in force |
| pstate_tgt | output | IDX_W | Level being moved to (equals pstate when idle) |
| req_volt | output | 1 | Voltage change requested for this phase |
| req_freq | output | 1 | Clock change requested for this phase |
| cpu_stall | output | 1 | Core held while a move settles |

## Verification
The main function is driven with runs of high samples, runs of low samples, high runs broken by a mid-band sample, and high runs broken by a low sample. A run that moves the level shows that the count reaches the window. A broken run that does not move shows that the clear or restart took effect. High samples are also sent during a move, then a short high run follows it. This tells a counter that restarted apart from one that kept the discarded samples. Moves are tried at both end levels, and an alarm is raised in the same cycle as a firing speed-up. These cases separate the saturation rules and the alarm's priority from the ordinary threshold path.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phase_t;
  typedef enum logic [1:0] {TR_NONE, TR_UP, TR_DN} trend_t;
endpackage

// File: rtl/dvfs_trend_filter.sv
module dvfs_trend_filter
  import dvfs_pkg::*;
#(
  parameter int UTIL_W = 7,
  parameter int WIN_W  = 8,
  parameter int UP_THR = 80,
  parameter int DN_THR = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UTIL_W-1:0] util_pct,
  input  logic              util_vld,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              busy,
  output logic              step_up,
  output logic              step_dn
);
  localparam logic [UTIL_W-1:0] HI_LIM = UTIL_W'(UP_THR);
  localparam logic [UTIL_W-1:0] LO_LIM = UTIL_W'(DN_THR);

  trend_t           trend_q, trend_d, band;
  logic [WIN_W-1:0] cnt_q, cnt_d, run;
  logic             take, fire, reg_en;

  always_comb begin
    if (util_pct > HI_LIM)      band = TR_UP;
    else if (util_pct < LO_LIM) band = TR_DN;
    else                        band = TR_NONE;
    take = util_vld && !busy;
    run  = (band == trend_q) ? cnt_q + WIN_W'(1) : WIN_W'(1);
    fire = take && (band != TR_NONE) && (run >= win_len);
    step_up = fire && (band == TR_UP);
    step_dn = fire && (band == TR_DN);
    reg_en  = busy || take;
    trend_d = trend_q;
    cnt_d   = cnt_q;
    if (busy || band == TR_NONE || fire) begin
      trend_d = TR_NONE;
      cnt_d   = '0;
    end else begin
      trend_d = band;
      cnt_d   = run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trend_q <= TR_NONE;
      cnt_q   <= '0;
    end else if (reg_en) begin
      trend_q <= trend_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(step_up || step_dn)); // R10
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R4
  AST_COUNT_CLEARED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/dvfs_pstate_seq.sv
module dvfs_pstate_seq
  import dvfs_pkg::*;
#(
  parameter int NUM_STATES = 4,
  localparam int IDX_W = (NUM_STATES > 2) ? $clog2(NUM_STATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             over_temp,
  input  logic             xfer_ack,
  output logic [IDX_W-1:0] pstate,
  output logic [IDX_W-1:0] pstate_tgt,
  output logic             req_volt,
  output logic             req_freq,
  output logic             cpu_stall
);
  localparam logic [IDX_W-1:0] SLOWEST = IDX_W'(NUM_STATES - 1);

  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] cur_q, cur_d, tgt_q, tgt_d;
  logic             rising_q, rising_d;
  logic             at_fast, at_slow, go_up, go_dn;

  always_comb begin
    at_fast  = (cur_q == '0);
    at_slow  = (cur_q == SLOWEST);
    go_up    = !over_temp && step_up && !at_fast;
    go_dn    = !at_slow && (over_temp || step_dn);
    phase_d  = phase_q;
    cur_d    = cur_q;
    tgt_d    = tgt_q;
    rising_d = rising_q;
    case (phase_q)
      PH_IDLE: begin
        if (go_up) begin
          phase_d  = PH_FIRST;
          tgt_d    = cur_q - IDX_W'(1);
          rising_d = 1'b1;
        end else if (go_dn) begin
          phase_d  = PH_FIRST;
          tgt_d    = cur_q + IDX_W'(1);
          rising_d = 1'b0;
        end
      end
      PH_FIRST: if (xfer_ack) phase_d = PH_SECOND;
      PH_SECOND: begin
        if (xfer_ack) begin
          phase_d = PH_IDLE;
          cur_d   = tgt_q;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cur_q    <= SLOWEST;
      tgt_q    <= SLOWEST;
      rising_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cur_q    <= cur_d;
      tgt_q    <= tgt_d;
      rising_q <= rising_d;
    end
  end

  assign pstate     = cur_q;
  assign pstate_tgt = tgt_q;
  assign cpu_stall  = (phase_q != PH_IDLE);
  assign req_volt   = (phase_q == PH_FIRST && rising_q) || (phase_q == PH_SECOND && !rising_q);
  assign req_freq   = (phase_q == PH_FIRST && !rising_q) || (phase_q == PH_SECOND && rising_q);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_volt && req_freq)); // R11
  AST_STALL_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && !xfer_ack) |=> cpu_stall); // R8
  AST_LEVEL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> ($past(phase_q) == PH_SECOND && $past(xfer_ack))); // R8
  AST_UP_VOLT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_freq) && rising_q) |-> $past(req_volt)); // R6
  AST_DN_FREQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_volt) && !rising_q) |-> $past(req_freq)); // R7
  AST_THERMAL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && !cpu_stall && !at_slow) |=> (cpu_stall && !rising_q)); // R5
  AST_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stall && at_fast && !step_dn && !over_temp) |=> !cpu_stall); // R9
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor #(
  parameter int NUM_STATES = 4,
  parameter int UTIL_W     = 7,
  parameter int WIN_W      = 8,
  parameter int UP_THR     = 80,
  parameter int DN_THR     = 30,
  localparam int IDX_W = (NUM_STATES > 2) ? $clog2(NUM_STATES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UTIL_W-1:0] util_pct,
  input  logic              util_vld,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              over_temp,
  input  logic              xfer_ack,
  output logic [IDX_W-1:0]  pstate,
  output logic [IDX_W-1:0]  pstate_tgt,
  output logic              req_volt,
  output logic              req_freq,
  output logic              cpu_stall
);
  logic step_up, step_dn;

  dvfs_trend_filter #(
    .UTIL_W(UTIL_W), .WIN_W(WIN_W), .UP_THR(UP_THR), .DN_THR(DN_THR)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .util_pct(util_pct), .util_vld(util_vld),
    .win_len(win_len), .busy(cpu_stall), .step_up(step_up), .step_dn(step_dn)
  );

  dvfs_pstate_seq #(.NUM_STATES(NUM_STATES)) u_seq (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .over_temp(over_temp), .xfer_ack(xfer_ack), .pstate(pstate),
    .pstate_tgt(pstate_tgt), .req_volt(req_volt), .req_freq(req_freq),
    .cpu_stall(cpu_stall)
  );
endmodule

// File: tb/dvfs_governor_tb.sv
module dvfs_governor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] util_pct = '0;
  logic       util_vld = 1'b0;
  logic [7:0] win_len = 8'd3;
  logic       over_temp = 1'b0;
  logic       xfer_ack = 1'b0;
  logic [1:0] pstate, pstate_tgt;
  logic       req_volt, req_freq, cpu_stall;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dvfs_governor u_dut (
    .clk(clk), .rst_n(rst_n), .util_pct(util_pct), .util_vld(util_vld),
    .win_len(win_len), .over_temp(over_temp), .xfer_ack(xfer_ack),
    .pstate(pstate), .pstate_tgt(pstate_tgt), .req_volt(req_volt),
    .req_freq(req_freq), .cpu_stall(cpu_stall)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sample(int u);
    @(negedge clk);
    util_pct = 7'(u);
    util_vld = 1'b1;
    @(negedge clk);
    util_vld = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  task automatic finish_move(string req, int lvl);
    ack_pulse();
    ack_pulse();
    chk(req, "stall after move", cpu_stall, 0);
    chk(req, "level after move", pstate, lvl);
  endtask

  task automatic t_reset();
    chk("R1", "pstate", pstate, 3);
    chk("R1", "pstate_tgt", pstate_tgt, 3);
    chk("R1", "stall", cpu_stall, 0);
    chk("R1", "requests", {req_volt, req_freq}, 0);
  endtask

  task automatic t_slow_edge();
    for (int i = 0; i < 3; i++) sample(10);
    chk("R9", "slow-down at slowest stall", cpu_stall, 0);
    @(negedge clk);
    over_temp = 1'b1;
    @(negedge clk);
    over_temp = 1'b0;
    chk("R9", "thermal at slowest stall", cpu_stall, 0);
    chk("R9", "level kept", pstate, 3);
  endtask

  task automatic t_speed_up();
    sample(90);
    sample(90);
    chk("R4", "short run stall", cpu_stall, 0);
    sample(90);
    chk("R2", "stall on window", cpu_stall, 1);
    chk("R2", "target", pstate_tgt, 2);
    chk("R6", "phase1 req_volt", req_volt, 1);
    chk("R6", "phase1 req_freq", req_freq, 0);
    chk("R8", "level held during move", pstate, 3);
    sample(90);
    sample(90);
    sample(90);
    chk("R8", "request held without ack", req_volt, 1);
    chk("R8", "stall held without ack", cpu_stall, 1);
    ack_pulse();
    chk("R6", "phase2 req_freq", req_freq, 1);
    chk("R6", "phase2 req_volt", req_volt, 0);
    chk("R8", "level held after first ack", pstate, 3);
    ack_pulse();
    chk("R8", "stall after second ack", cpu_stall, 0);
    chk("R8", "level after second ack", pstate, 2);
    sample(90);
    sample(90);
    chk("R10", "count restarted after move", cpu_stall, 0);
  endtask

  task automatic t_window_breaks();
    sample(50);
    sample(90);
    sample(90);
    sample(50);
    sample(90);
    sample(90);
    chk("R4", "mid-band clears count", cpu_stall, 0);
    sample(90);
    chk("R2", "fires after clean run", cpu_stall, 1);
    finish_move("R2", 1);
    sample(10);
    sample(10);
    sample(90);
    sample(90);
    chk("R4", "opposite band restarts", cpu_stall, 0);
    sample(90);
    chk("R4", "fires after restart", cpu_stall, 1);
    finish_move("R2", 0);
  endtask

  task automatic t_fast_edge();
    for (int i = 0; i < 3; i++) sample(95);
    chk("R9", "speed-up at fastest stall", cpu_stall, 0);
    chk("R9", "level kept at fastest", pstate, 0);
  endtask

  task automatic t_slow_down();
    sample(10);
    sample(10);
    sample(29);
    chk("R3", "stall on low window", cpu_stall, 1);
    chk("R3", "target", pstate_tgt, 1);
    chk("R7", "phase1 req_freq", req_freq, 1);
    chk("R7", "phase1 req_volt", req_volt, 0);
    ack_pulse();
    chk("R7", "phase2 req_volt", req_volt, 1);
    chk("R7", "phase2 req_freq", req_freq, 0);
    ack_pulse();
    chk("R3", "level after slow-down", pstate, 1);
    chk("R11", "requests clear when idle", {req_volt, req_freq}, 0);
  endtask

  task automatic t_thermal();
    sample(90);
    sample(90);
    @(negedge clk);
    util_pct  = 7'd90;
    util_vld  = 1'b1;
    over_temp = 1'b1;
    @(negedge clk);
    util_vld  = 1'b0;
    over_temp = 1'b0;
    chk("R5", "thermal stall", cpu_stall, 1);
    chk("R5", "thermal target beats speed-up", pstate_tgt, 2);
    chk("R5", "thermal clock first", req_freq, 1);
    finish_move("R5", 2);
    @(negedge clk);
    over_temp = 1'b1;
    @(negedge clk);
    over_temp = 1'b0;
    chk("R5", "no window for alarm", cpu_stall, 1);
    chk("R5", "alarm target", pstate_tgt, 3);
    finish_move("R5", 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slow_edge();
    t_speed_up();
    t_window_breaks();
    t_fast_edge();
    t_slow_down();
    t_thermal();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule